// File: doc/BRIEF.md
# Interlock Hazard Controller

This block is the control logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no operand bypassing at all. Each cycle it looks at the register IDs the decode stage wants to read, the destination IDs still travelling through the later stages, the operation codes in decode, execute and memory, and the condition result of the execute stage. From these it decides which pipeline registers must hold their contents (stall) and which must be loaded with a no-operation (bubble).

It recognises three situations. The first is a read-after-write conflict, where an older instruction has not yet written a register that decode needs. The second is a pending return, where the next fetch address is not yet known. The third is a wrongly predicted conditional jump, detected in execute. When several occur at once, a fixed priority applies. A misprediction beats everything, because every younger instruction is on the wrong path. A read-after-write conflict beats a pending return. The block is purely combinational, and its outputs follow its inputs in the same cycle. All of its pins are plain control signals, because no data stream crosses its edge.

Top module: `hzc_interlock`

## Requirements
- R1: A read-after-write conflict exists when `dec_src_a` or `dec_src_b` is not 4'hF and equals any of the six destinations `exe_dst_alu`, `exe_dst_mem`, `mem_dst_alu`, `mem_dst_mem`, `wb_dst_alu` or `wb_dst_mem`.
- R2: The code 4'hF means "no register". A source of 4'hF never causes a conflict, and a destination of 4'hF never matches any source.
- R3: A pending return exists when any of `dec_op`, `exe_op` or `mem_op` equals 4'h9, the return code.
- R4: A misprediction exists when `exe_op` equals 4'h7, the jump code, and `exe_cond_ok` is 0. A jump whose condition is 1 is no misprediction.
- R5: A conflict alone drives `f_stall`=1, `d_stall`=1 and `e_bubble`=1. All other controls are 0.
- R6: A pending return alone drives `f_stall`=1 and `d_bubble`=1. All other controls are 0.
- R7: A misprediction, alone or together with any other situation, drives `d_bubble`=1 and `e_bubble`=1. All other controls are 0, so `f_stall` and `d_stall` are 0.
- R8: A conflict together with a pending return, without a misprediction, gives the same outputs as the conflict alone (R5).
- R9: `f_bubble`, `e_stall`, `m_stall`, `m_bubble`, `w_stall` and `w_bubble` are 0 for every input.
- R10: No pipeline register ever has its stall and its bubble at 1 together.
- R11: With none of the three situations present, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 4 | First source register ID read in decode |
| dec_src_b | input | 4 | Second source register ID read in decode |
| exe_dst_alu | input | 4 | Computed ALU destination of the execute stage |
| exe_dst_mem | input | 4 | Load destination held in the execute stage |
| mem_dst_alu | input | 4 | ALU destination held in the memory stage |
| mem_dst_mem | input | 4 | Load destination held in the memory stage |
| wb_dst_alu | input | 4 | ALU destination held in the writeback stage |
| wb_dst_mem | input | 4 | Load destination held in the writeback stage |
| dec_op | input | 4 | Operation code in decode |
| exe_op | input | 4 | Operation code in execute |
| mem_op | input | 4 | Operation code in memory |
| exe_cond_ok | input | 1 | Evaluated condition of the execute-stage instruction |
| f_stall | output | 1 | Hold the fetch register |
| f_bubble | output | 1 | Load a no-op into the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a no-op into the decode register |
| e_stall | output | 1 | Hold the execute register |
| e_bubble | output | 1 | Load a no-op into the execute register |
| m_stall | output | 1 | Hold the memory register |
| m_bubble | output | 1 | Load a no-op into the memory register |
| w_stall | output | 1 | Hold the writeback register |
| w_bubble | output | 1 | Load a no-op into the writeback register |

## Verification
The block holds no state, so any wrong internal term shows at the stall and bubble pins in the same cycle that the triggering stage fields are applied. A missing comparator shows as a cleared `d_stall` when a source matches exactly that destination slot. A broken priority shows as `f_stall` or `d_stall` raised beside a misprediction, or as `d_bubble` raised beside a conflict. Directed cases cover each destination slot, each stage holding a return, and both jump outcomes. Biased random fields cover the mixed cases, and every cycle is compared against a behavioural model.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int REG_W  = 4;
  localparam int CODE_W = 4;

  localparam logic [REG_W-1:0]  REG_NONE = 4'hF;
  localparam logic [CODE_W-1:0] OP_HALT  = 4'h0;
  localparam logic [CODE_W-1:0] OP_NOP   = 4'h1;
  localparam logic [CODE_W-1:0] OP_MOVRR = 4'h2;
  localparam logic [CODE_W-1:0] OP_MOVIR = 4'h3;
  localparam logic [CODE_W-1:0] OP_STORE = 4'h4;
  localparam logic [CODE_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [CODE_W-1:0] OP_ALU   = 4'h6;
  localparam logic [CODE_W-1:0] OP_JUMP  = 4'h7;
  localparam logic [CODE_W-1:0] OP_CALL  = 4'h8;
  localparam logic [CODE_W-1:0] OP_RET   = 4'h9;
  localparam logic [CODE_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [CODE_W-1:0] OP_POP   = 4'hB;

  typedef enum int {
    STG_F = 0,
    STG_D = 1,
    STG_E = 2,
    STG_M = 3,
    STG_W = 4
  } stage_e;

  localparam int NUM_STAGES = 5;

  typedef struct packed {
    logic conflict;
    logic ret_wait;
    logic mispredict;
  } cause_t;
endpackage

// File: rtl/hzc_raw_detect.sv
module hzc_raw_detect #(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 2,
  parameter int NUM_DST = 6
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_ids,
  input  logic [NUM_DST-1:0][REG_W-1:0] dst_ids,
  output logic                          conflict
);
  localparam logic [REG_W-1:0] NONE_ID = {REG_W{1'b1}};
  localparam int NUM_PAIRS = NUM_SRC * NUM_DST;

  logic [NUM_PAIRS-1:0] pair_hit;

  // One equality comparator per (source, destination) pair.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic src_live;
    assign src_live = (src_ids[s] != NONE_ID);
    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
      assign pair_hit[s*NUM_DST + d] = src_live
                                     && (dst_ids[d] != NONE_ID)
                                     && (src_ids[s] == dst_ids[d]);
    end
  end

  assign conflict = |pair_hit;
endmodule

// File: rtl/hzc_event_detect.sv
module hzc_event_detect #(
  parameter int CODE_W    = 4,
  parameter int NUM_WATCH = 3,
  parameter logic [CODE_W-1:0] RET_CODE  = 4'h9,
  parameter logic [CODE_W-1:0] JUMP_CODE = 4'h7
) (
  input  logic [NUM_WATCH-1:0][CODE_W-1:0] watch_ops,
  input  logic [CODE_W-1:0]                exe_op,
  input  logic                             exe_cond_ok,
  output logic                             ret_wait,
  output logic                             mispredict
);
  logic [NUM_WATCH-1:0] is_ret;

  for (genvar k = 0; k < NUM_WATCH; k++) begin : g_watch
    assign is_ret[k] = (watch_ops[k] == RET_CODE);
  end

  assign ret_wait   = |is_ret;
  assign mispredict = (exe_op == JUMP_CODE) && !exe_cond_ok;
endmodule

// File: rtl/hzc_resolver.sv
module hzc_resolver
  import hzc_pkg::*;
#(
  parameter int STAGES = NUM_STAGES
) (
  input  cause_t            cause,
  output logic [STAGES-1:0] stall,
  output logic [STAGES-1:0] bubble
);
  // Priority: misprediction, then conflict, then pending return.
  logic take_pred, take_conf, take_ret;

  always_comb begin
    take_pred = cause.mispredict;
    take_conf = cause.conflict && !cause.mispredict;
    take_ret  = cause.ret_wait && !cause.conflict && !cause.mispredict;
  end

  always_comb begin
    stall  = '0;
    bubble = '0;
    stall[STG_F]  = take_conf || take_ret;
    stall[STG_D]  = take_conf;
    bubble[STG_D] = take_pred || take_ret;
    bubble[STG_E] = take_pred || take_conf;
  end
endmodule

// File: rtl/hzc_interlock.sv
module hzc_interlock
  import hzc_pkg::*;
(
  input  logic [3:0] dec_src_a,
  input  logic [3:0] dec_src_b,
  input  logic [3:0] exe_dst_alu,
  input  logic [3:0] exe_dst_mem,
  input  logic [3:0] mem_dst_alu,
  input  logic [3:0] mem_dst_mem,
  input  logic [3:0] wb_dst_alu,
  input  logic [3:0] wb_dst_mem,
  input  logic [3:0] dec_op,
  input  logic [3:0] exe_op,
  input  logic [3:0] mem_op,
  input  logic       exe_cond_ok,
  output logic       f_stall,
  output logic       f_bubble,
  output logic       d_stall,
  output logic       d_bubble,
  output logic       e_stall,
  output logic       e_bubble,
  output logic       m_stall,
  output logic       m_bubble,
  output logic       w_stall,
  output logic       w_bubble
);
  localparam int NSRC   = 2;
  localparam int NDST   = 6;
  localparam int NWATCH = 3;

  logic [NSRC-1:0][REG_W-1:0]    srcs;
  logic [NDST-1:0][REG_W-1:0]    dsts;
  logic [NWATCH-1:0][CODE_W-1:0] ops;
  cause_t                        cause;
  logic [NUM_STAGES-1:0]         stall_v;
  logic [NUM_STAGES-1:0]         bubble_v;

  assign srcs = {dec_src_b, dec_src_a};
  assign dsts = {wb_dst_mem, wb_dst_alu, mem_dst_mem, mem_dst_alu,
                 exe_dst_mem, exe_dst_alu};
  assign ops  = {mem_op, exe_op, dec_op};

  hzc_raw_detect #(
    .REG_W  (REG_W),
    .NUM_SRC(NSRC),
    .NUM_DST(NDST)
  ) u_raw (
    .src_ids (srcs),
    .dst_ids (dsts),
    .conflict(cause.conflict)
  );

  hzc_event_detect #(
    .CODE_W   (CODE_W),
    .NUM_WATCH(NWATCH),
    .RET_CODE (OP_RET),
    .JUMP_CODE(OP_JUMP)
  ) u_evt (
    .watch_ops  (ops),
    .exe_op     (exe_op),
    .exe_cond_ok(exe_cond_ok),
    .ret_wait   (cause.ret_wait),
    .mispredict (cause.mispredict)
  );

  hzc_resolver #(
    .STAGES(NUM_STAGES)
  ) u_res (
    .cause (cause),
    .stall (stall_v),
    .bubble(bubble_v)
  );

  assign f_stall  = stall_v[STG_F];
  assign f_bubble = bubble_v[STG_F];
  assign d_stall  = stall_v[STG_D];
  assign d_bubble = bubble_v[STG_D];
  assign e_stall  = stall_v[STG_E];
  assign e_bubble = bubble_v[STG_E];
  assign m_stall  = stall_v[STG_M];
  assign m_bubble = bubble_v[STG_M];
  assign w_stall  = stall_v[STG_W];
  assign w_bubble = bubble_v[STG_W];
endmodule

// File: rtl/hzc_interlock_chk.sv
module hzc_interlock_chk (
  input logic [3:0] dec_src_a,
  input logic [3:0] dec_src_b,
  input logic [3:0] exe_dst_alu,
  input logic [3:0] exe_dst_mem,
  input logic [3:0] mem_dst_alu,
  input logic [3:0] mem_dst_mem,
  input logic [3:0] wb_dst_alu,
  input logic [3:0] wb_dst_mem,
  input logic [3:0] dec_op,
  input logic [3:0] exe_op,
  input logic [3:0] mem_op,
  input logic       exe_cond_ok,
  input logic       f_stall,
  input logic       f_bubble,
  input logic       d_stall,
  input logic       d_bubble,
  input logic       e_stall,
  input logic       e_bubble,
  input logic       m_stall,
  input logic       m_bubble,
  input logic       w_stall,
  input logic       w_bubble
);
  logic wrong_path, ret_seen, a_hits_wb;

  always_comb begin
    wrong_path = (exe_op == 4'h7) && (exe_cond_ok == 1'b0);
    ret_seen   = (dec_op == 4'h9) || (exe_op == 4'h9) || (mem_op == 4'h9);
    a_hits_wb  = (dec_src_a != 4'hF) && (dec_src_a == wb_dst_mem);

    // R7: misprediction wins over everything
    a_r7_flush_only: assert (!wrong_path ||
      (d_bubble && e_bubble && !f_stall && !d_stall))
      else $error("R7 misprediction controls wrong");

    // R3: pending return without a misprediction always holds fetch
    a_r3_ret_holds_fetch: assert (wrong_path || !ret_seen || f_stall)
      else $error("R3 return did not hold fetch");

    // R1: oldest load destination still blocks decode
    a_r1_wb_match_stalls: assert (wrong_path || !a_hits_wb ||
      (d_stall && e_bubble && !d_bubble))
      else $error("R1 writeback match missed");

    // R9: controls that are never used stay low
    a_r9_quiet_controls: assert (!f_bubble && !e_stall && !m_stall &&
      !m_bubble && !w_stall && !w_bubble)
      else $error("R9 unused control raised");

    // R10: no register is both held and flushed
    a_r10_exclusive: assert (!(f_stall && f_bubble) && !(d_stall && d_bubble)
      && !(e_stall && e_bubble))
      else $error("R10 stall and bubble together");

    // R5: a decode stall always comes with an execute bubble
    a_r5_stall_pairs_bubble: assert (!d_stall || (f_stall && e_bubble))
      else $error("R5 decode stall without pairing");
  end
endmodule

bind hzc_interlock hzc_interlock_chk u_chk (
  .dec_src_a  (dec_src_a),
  .dec_src_b  (dec_src_b),
  .exe_dst_alu(exe_dst_alu),
  .exe_dst_mem(exe_dst_mem),
  .mem_dst_alu(mem_dst_alu),
  .mem_dst_mem(mem_dst_mem),
  .wb_dst_alu (wb_dst_alu),
  .wb_dst_mem (wb_dst_mem),
  .dec_op     (dec_op),
  .exe_op     (exe_op),
  .mem_op     (mem_op),
  .exe_cond_ok(exe_cond_ok),
  .f_stall    (f_stall),
  .f_bubble   (f_bubble),
  .d_stall    (d_stall),
  .d_bubble   (d_bubble),
  .e_stall    (e_stall),
  .e_bubble   (e_bubble),
  .m_stall    (m_stall),
  .m_bubble   (m_bubble),
  .w_stall    (w_stall),
  .w_bubble   (w_bubble)
);

// File: tb/tb_hzc_interlock.sv
`timescale 1ns/1ps
module tb_hzc_interlock;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] src_a, src_b;
  logic [3:0] dst [6];
  logic [3:0] op_d, op_e, op_m;
  logic       cond;
  logic f_s, f_b, d_s, d_b, e_s, e_b, m_s, m_b, w_s, w_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hzc_interlock dut (
    .dec_src_a(src_a), .dec_src_b(src_b),
    .exe_dst_alu(dst[0]), .exe_dst_mem(dst[1]),
    .mem_dst_alu(dst[2]), .mem_dst_mem(dst[3]),
    .wb_dst_alu(dst[4]),  .wb_dst_mem(dst[5]),
    .dec_op(op_d), .exe_op(op_e), .mem_op(op_m), .exe_cond_ok(cond),
    .f_stall(f_s), .f_bubble(f_b), .d_stall(d_s), .d_bubble(d_b),
    .e_stall(e_s), .e_bubble(e_b), .m_stall(m_s), .m_bubble(m_b),
    .w_stall(w_s), .w_bubble(w_b)
  );

  // Behavioural reference: output vector {w_b,w_s,m_b,m_s,e_b,e_s,d_b,d_s,f_b,f_s}
  function automatic logic [9:0] model(output string tag);
    bit conf = 0, ret = 0, pred;
    int wanted [2];
    logic [9:0] v = '0;
    wanted[0] = src_a; wanted[1] = src_b;
    foreach (wanted[i]) begin
      if (wanted[i] == 15) continue;
      foreach (dst[j]) if (int'(dst[j]) == wanted[i]) conf = 1;
    end
    ret  = (op_d == 9) || (op_e == 9) || (op_m == 9);
    pred = (op_e == 7) && !cond;
    if (pred) begin
      v[5] = 1; v[3] = 1; tag = "R7";
    end else if (conf) begin
      v[0] = 1; v[2] = 1; v[5] = 1; tag = ret ? "R8" : "R5";
    end else if (ret) begin
      v[0] = 1; v[3] = 1; tag = "R6";
    end else tag = "R11";
    return v;
  endfunction

  function automatic logic [9:0] actual();
    return {w_b, w_s, m_b, m_s, e_b, e_s, d_b, d_s, f_b, f_s};
  endfunction

  task automatic check_vec(input string tag);
    logic [9:0] exp_v;
    string      cls;
    @(negedge clk);
    exp_v = model(cls);
    checks++;
    if (actual() !== exp_v) begin
      errors++;
      $display("FAIL %s/%s: got %b expected %b", tag, cls, actual(), exp_v);
    end
    checks++;
    if ({w_b, w_s, m_b, m_s, e_s, f_b} !== 6'b0) begin
      errors++;
      $display("FAIL R9: unused controls %b expected 000000",
               {w_b, w_s, m_b, m_s, e_s, f_b});
    end
    checks++;
    if ((f_s && f_b) || (d_s && d_b) || (e_s && e_b)) begin
      errors++;
      $display("FAIL R10: pairs f=%b%b d=%b%b e=%b%b expected no 11",
               f_s, f_b, d_s, d_b, e_s, e_b);
    end
  endtask

  task automatic idle();
    @(posedge clk);
    src_a = 4'hF; src_b = 4'hF;
    foreach (dst[j]) dst[j] = 4'hF;
    op_d = 4'h1; op_e = 4'h1; op_m = 4'h1; cond = 1'b1;
  endtask

  function automatic logic [3:0] pick_reg();
    int r = $urandom_range(0, 5);
    return (r >= 4) ? 4'hF : 4'(r);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, cycles %0d expected below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    check_vec("R11 reset-idle");

    // R1: each destination slot alone, matched by A then by B
    for (int j = 0; j < 6; j++) begin
      idle(); src_a = 4'd3; dst[j] = 4'd3; check_vec("R1 src A slot");
      idle(); src_b = 4'd7; dst[j] = 4'd7; check_vec("R1 src B slot");
    end
    // R2: no-register codes never match
    idle(); src_a = 4'hF; dst[2] = 4'hF; check_vec("R2 none source");
    idle(); src_a = 4'd2; src_b = 4'd4; check_vec("R2 none destinations");
    // R3: return in each watched stage, and R11 for writeback-only style idle
    idle(); op_d = 4'h9; check_vec("R3 return decode");
    idle(); op_e = 4'h9; check_vec("R3 return execute");
    idle(); op_m = 4'h9; check_vec("R3 return memory");
    // R4: jump outcomes
    idle(); op_e = 4'h7; cond = 1'b1; check_vec("R4 jump taken ok");
    idle(); op_e = 4'h7; cond = 1'b0; check_vec("R4 jump wrong");
    idle(); op_e = 4'h6; cond = 1'b0; check_vec("R4 non-jump false cond");
    // R8: conflict plus return
    idle(); op_d = 4'h9; src_b = 4'd4; dst[0] = 4'd4; check_vec("R8 conflict+ret");
    // R7: misprediction with everything else
    idle(); op_e = 4'h7; cond = 1'b0; op_m = 4'h9; src_a = 4'd1; dst[5] = 4'd1;
    check_vec("R7 all together");

    // Biased random mix, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk);
      src_a = pick_reg(); src_b = pick_reg();
      foreach (dst[j]) dst[j] = pick_reg();
      op_d = 4'($urandom_range(0, 11));
      op_e = ($urandom_range(0, 3) == 0) ? 4'h7 : 4'($urandom_range(0, 11));
      op_m = 4'($urandom_range(0, 11));
      cond = 1'($urandom_range(0, 1));
      check_vec("random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule